// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block drives the SDRAM command pins of a simple memory bus controller whenever refresh is required. An up-counter compared against a software-written limit raises a periodic request. Each request becomes an auto-refresh: a precharge of all banks, one refresh command, then a fixed recovery window during which the bus controller must keep away from the device (the busy output is high).

Software can instead put the device into self-refresh. With refresh enabled and the self mode selected, the sequencer precharges all banks and then issues a refresh command with the clock-enable pin driven low in that same cycle. Clock enable then stays low until software deselects the self mode. A manual reset does not end this state, and neither does chip standby. Only software or a power-on reset ends it. On exit, clock enable rises and a post-wait window follows. Auto-refresh then resumes only if refresh is enabled and the self mode is deselected. Software may preload the counter so that the first refresh after exit is issued at once.

During standby the pins are either held driven or released, as selected by a keep-driven input.

Top module: `sdram_rfsh_ctl`

## Requirements
- R1: With refresh enabled (ctl_rfen=1) and self mode off (ctl_srmode=0), after the limit register is written with value C (C > TRC+3) together with a counter load of 0, precharge commands appear exactly C cycles apart.
- R2: The auto-refresh sequence is as follows. First, one precharge cycle (cs_n,ras_n,cas_n,we_n = 0,0,1,0) with sd_a10=1. Next, one refresh cycle (0,0,0,1) with sd_a10=0 and sd_cke=1. Then TRC no-operation cycles (1,1,1,1) with rf_busy=1, after which rf_busy=0. Every non-NOP command occurs while rf_busy=1.
- R3: When ctl_rfen=1 and ctl_srmode=1 are written, the sequencer issues a precharge (sd_a10=1) and then a refresh with sd_cke=0. It then holds sd_cke=0, rf_busy=1 and NOP on all later cycles, and issues no auto-refresh.
- R4: When ctl_srmode is written to 0 during self-refresh, sd_cke returns to 1. rf_busy then stays 1 with NOP for exactly TPW cycles.
- R5: After self-refresh exit, no command is issued if ctl_rfen=0.
- R6: If the counter is loaded with C-1 before exit with ctl_rfen=1, the precharge is seen two cycles after the first cycle with rf_busy=0.
- R7: A manual reset (mrst_n low for one cycle) leaves sd_cke low during self-refresh. In auto mode it restarts the counter from 0, so the next precharge is seen C+1 clock edges after the reset edge.
- R8: Self-refresh (sd_cke=0) persists through standby and after it ends. During standby, sd_oe=1 if hiz_keep=1 and sd_oe=0 if hiz_keep=0. Outside standby, sd_oe=1.
- R9: Power-on reset forces sd_cke=1, rf_busy=0 and NOP, and clears both control bits, so no command follows release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| standby | input | 1 | Chip standby indication |
| hiz_keep | input | 1 | Keep pins driven during standby |
| ctl_wr | input | 1 | Write strobe for the two control bits |
| ctl_rfen | input | 1 | Refresh enable value |
| ctl_srmode | input | 1 | Self mode value (1 = self-refresh) |
| cmp_wr | input | 1 | Write strobe for the limit register |
| cnt_wr | input | 1 | Load strobe for the refresh counter |
| wdata | input | CW | Data for the limit or counter write |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_a10 | output | 1 | Address bit for precharge-all |
| sd_oe | output | 1 | Pin drive enable |
| rf_busy | output | 1 | Sequencer owns the bus |

## Verification
Some properties are checked on every cycle. Every precharge carries the all-banks bit and is followed by a refresh. Clock enable only falls together with a refresh command, and only NOP appears while it stays low. A rise of clock enable starts a busy post-wait. A manual reset cannot lift clock enable while the self mode is set. Other behaviour needs the bench scenarios, because each depends on a history of register writes: the exact refresh period for each limit value, the counter restart after a manual reset, the immediate refresh after a preloaded exit, the pin release in standby, and the silence after exit with refresh disabled or after power-on reset.

// File: rtl/sdrf_pkg.sv
package sdrf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_APRE,
    ST_AREF,
    ST_ARC,
    ST_SPRE,
    ST_SREF,
    ST_SRC,
    ST_SHOLD,
    ST_SPW
  } sdrf_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdrf_cmd_t;

  localparam sdrf_cmd_t CMD_NOP = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdrf_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdrf_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdrf_rst_sync.sv
module sdrf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/sdrf_timer.sv
module sdrf_timer #(
  parameter int          CW      = 8,
  parameter logic [CW-1:0] CMP_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          cnt_wr,
  input  logic          cmp_wr,
  input  logic [CW-1:0] wdata,
  output logic          tick
);

  logic [CW-1:0] cnt_q, cnt_d, cmp_q, inc;
  logic          cnt_en;

  assign inc    = cnt_q + CW'(1);
  assign cnt_en = clr | cnt_wr | run;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_wr) begin
      cnt_d = wdata;
    end else if (run) begin
      if (inc == cmp_q) begin
        tick  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= CMP_RST;
    end else if (cmp_wr) begin
      cmp_q <= wdata;
    end
  end

endmodule

// File: rtl/sdrf_seq.sv
module sdrf_seq
  import sdrf_pkg::*;
#(
  parameter int TRC = 3,
  parameter int TPW = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mrst,
  input  logic        rf_en,
  input  logic        sr_mode,
  input  logic        tick,
  output sdrf_state_e state,
  output logic        sr_hold,
  output logic        busy
);

  localparam int WMAX = (TRC > TPW) ? TRC : TPW;
  localparam int WW   = (WMAX > 1) ? $clog2(WMAX) : 1;
  localparam logic [WW-1:0] RC_LOAD = WW'(TRC - 1);
  localparam logic [WW-1:0] PW_LOAD = WW'(TPW - 1);

  sdrf_state_e   state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          pend_q, pend_d;
  logic          take;
  logic          sr_go;

  assign sr_go = rf_en & sr_mode;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_go) begin
          state_d = ST_SPRE;
          take    = 1'b1;
        end else if (pend_q) begin
          state_d = ST_APRE;
          take    = 1'b1;
        end
      end
      ST_APRE: state_d = ST_AREF;
      ST_AREF: begin
        state_d = ST_ARC;
        wcnt_d  = RC_LOAD;
      end
      ST_ARC: begin
        if (wcnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          wcnt_d = wcnt_q - WW'(1);
        end
      end
      ST_SPRE: state_d = ST_SREF;
      ST_SREF: begin
        state_d = ST_SRC;
        wcnt_d  = RC_LOAD;
      end
      ST_SRC: begin
        if (wcnt_q == '0) begin
          state_d = ST_SHOLD;
        end else begin
          wcnt_d = wcnt_q - WW'(1);
        end
      end
      ST_SHOLD: begin
        if (!sr_mode) begin
          state_d = ST_SPW;
          wcnt_d  = PW_LOAD;
        end
      end
      ST_SPW: begin
        if (wcnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          wcnt_d = wcnt_q - WW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (mrst) begin
      pend_d = 1'b0;
    end else begin
      pend_d = (pend_q & ~take) | tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      pend_q  <= pend_d;
    end
  end

  assign state   = state_q;
  assign busy    = (state_q != ST_IDLE);
  assign sr_hold = (state_q == ST_SPRE) | (state_q == ST_SREF) | (state_q == ST_SRC) |
                   (state_q == ST_SHOLD) | (state_q == ST_SPW);

endmodule

// File: rtl/sdrf_pins.sv
module sdrf_pins
  import sdrf_pkg::*;
(
  input  sdrf_state_e state,
  input  logic        standby,
  input  logic        hiz_keep,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic        cke,
  output logic        a10,
  output logic        oe
);

  sdrf_cmd_t cmd;

  always_comb begin
    cmd = CMD_NOP;
    a10 = 1'b0;
    cke = 1'b1;
    unique case (state)
      ST_APRE, ST_SPRE: begin
        cmd = CMD_PRE;
        a10 = 1'b1;
      end
      ST_AREF: cmd = CMD_REF;
      ST_SREF: begin
        cmd = CMD_REF;
        cke = 1'b0;
      end
      ST_SRC, ST_SHOLD: cke = 1'b0;
      default: cmd = CMD_NOP;
    endcase
  end

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign oe    = ~(standby & ~hiz_keep);

endmodule

// File: rtl/sdram_rfsh_ctl.sv
module sdram_rfsh_ctl
  import sdrf_pkg::*;
#(
  parameter int CW  = 8,
  parameter int TRC = 3,
  parameter int TPW = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mrst_n,
  input  logic          standby,
  input  logic          hiz_keep,
  input  logic          ctl_wr,
  input  logic          ctl_rfen,
  input  logic          ctl_srmode,
  input  logic          cmp_wr,
  input  logic          cnt_wr,
  input  logic [CW-1:0] wdata,
  output logic          sd_cs_n,
  output logic          sd_ras_n,
  output logic          sd_cas_n,
  output logic          sd_we_n,
  output logic          sd_cke,
  output logic          sd_a10,
  output logic          sd_oe,
  output logic          rf_busy
);

  logic        rst_n;
  logic        rfen_q, srmode_q;
  logic        tick, sr_hold, run;
  sdrf_state_e state;

  sdrf_rst_sync u_rst (
    .clk    (clk),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfen_q   <= 1'b0;
      srmode_q <= 1'b0;
    end else if (ctl_wr) begin
      rfen_q   <= ctl_rfen;
      srmode_q <= ctl_srmode;
    end
  end

  assign run = rfen_q & ~srmode_q & ~sr_hold;

  sdrf_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~mrst_n),
    .run    (run),
    .cnt_wr (cnt_wr),
    .cmp_wr (cmp_wr),
    .wdata  (wdata),
    .tick   (tick)
  );

  sdrf_seq #(.TRC(TRC), .TPW(TPW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mrst    (~mrst_n),
    .rf_en   (rfen_q),
    .sr_mode (srmode_q),
    .tick    (tick),
    .state   (state),
    .sr_hold (sr_hold),
    .busy    (rf_busy)
  );

  sdrf_pins u_pins (
    .state    (state),
    .standby  (standby),
    .hiz_keep (hiz_keep),
    .cs_n     (sd_cs_n),
    .ras_n    (sd_ras_n),
    .cas_n    (sd_cas_n),
    .we_n     (sd_we_n),
    .cke      (sd_cke),
    .a10      (sd_a10),
    .oe       (sd_oe)
  );

endmodule

// File: rtl/sdrf_chk.sv
module sdrf_chk (
  input logic clk,
  input logic rst_n,
  input logic mrst_n,
  input logic srmode,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic a10,
  input logic busy
);

  logic is_pre, is_ref, is_nop;
  assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_nop =  cs_n &&  ras_n &&  cas_n &&  we_n;

  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> a10);  // R2
  AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> is_ref);  // R2
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> busy);  // R2
  AST_CKE_FALL_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> is_ref);  // R3
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> (is_nop && busy));  // R3
  AST_EXIT_POST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (busy && is_nop));  // R4
  AST_MRST_KEEPS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst_n && !cke && srmode) |=> !cke);  // R7

endmodule

bind sdram_rfsh_ctl sdrf_chk u_sdrf_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mrst_n (mrst_n),
  .srmode (srmode_q),
  .cs_n   (sd_cs_n),
  .ras_n  (sd_ras_n),
  .cas_n  (sd_cas_n),
  .we_n   (sd_we_n),
  .cke    (sd_cke),
  .a10    (sd_a10),
  .busy   (rf_busy)
);

// File: tb/test_sdram_rfsh_ctl.sv
`timescale 1ns/1ps
module test_sdram_rfsh_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int TRC = 3;
  localparam int TPW = 2;

  logic clk = 1'b0;
  logic por_n, mrst_n, standby, hiz_keep;
  logic ctl_wr, ctl_rfen, ctl_srmode, cmp_wr, cnt_wr;
  logic [CW-1:0] wdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_a10, sd_oe, rf_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_rfsh_ctl #(.CW(CW), .TRC(TRC), .TPW(TPW)) i_sdram_rfsh_ctl (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby), .hiz_keep(hiz_keep),
    .ctl_wr(ctl_wr), .ctl_rfen(ctl_rfen), .ctl_srmode(ctl_srmode),
    .cmp_wr(cmp_wr), .cnt_wr(cnt_wr), .wdata(wdata),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cke(sd_cke), .sd_a10(sd_a10), .sd_oe(sd_oe), .rf_busy(rf_busy)
  );

  function automatic bit is_pre();
    return !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n;
  endfunction
  function automatic bit is_ref();
    return !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n;
  endfunction
  function automatic bit is_nop();
    return sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input bit rfen, input bit srm);
    ctl_wr = 1'b1; ctl_rfen = rfen; ctl_srmode = srm;
    cyc(1);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_timer(input bit do_cmp, input bit do_cnt, input int cmpv, input int cntv);
    if (do_cmp) begin
      wdata = CW'(cmpv); cmp_wr = 1'b1;
    end
    if (do_cnt && !do_cmp) begin
      wdata = CW'(cntv); cnt_wr = 1'b1;
    end
    cyc(1);
    cmp_wr = 1'b0;
    if (do_cnt && do_cmp) begin
      wdata = CW'(cntv); cnt_wr = 1'b1;
      cyc(1);
    end
    cnt_wr = 1'b0;
  endtask

  task automatic wait_pre(output int n);
    n = 0;
    while (!is_pre() && n < 400) begin
      cyc(1);
      n++;
    end
  endtask

  task automatic wait_cke(input bit v, output int n);
    n = 0;
    while (sd_cke != v && n < 400) begin
      cyc(1);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, bad;
    por_n = 1'b0; mrst_n = 1'b1; standby = 1'b0; hiz_keep = 1'b0;
    ctl_wr = 1'b0; ctl_rfen = 1'b0; ctl_srmode = 1'b0;
    cmp_wr = 1'b0; cnt_wr = 1'b0; wdata = '0;
    cyc(3);
    por_n = 1'b1;
    cyc(4);
    // R9 reset state
    chk(sd_cke && !rf_busy && is_nop() && sd_oe, "R9 reset state", {sd_cke, rf_busy}, 2);

    // R1 / R2: period sweep with sequence shape checks
    wr_ctl(1'b1, 1'b0);
    for (int c = 8; c <= 24; c++) begin
      wr_timer(1'b1, 1'b1, c, 0);
      wait_pre(n);
      n = 0;
      bad = 0;
      do begin
        cyc(1);
        n++;
        if (n == 1 && !(is_ref() && !sd_a10 && sd_cke)) bad++;
        if (n >= 2 && n <= TRC + 1 && !(is_nop() && rf_busy)) bad++;
        if (n == TRC + 2 && rf_busy) bad++;
      end while (!is_pre() && n < 400);
      chk(sd_a10 == 1'b1, "R2 precharge all banks", sd_a10, 1);
      chk(bad == 0, "R2 refresh sequence", bad, 0);
      chk(n == c, "R1 refresh period", n, c);
    end

    // R7 manual reset restarts the counter
    wr_timer(1'b1, 1'b1, 30, 0);
    wait_pre(n);
    cyc(TRC + 5);
    mrst_n = 1'b0;
    cyc(1);
    mrst_n = 1'b1;
    n = 0;
    while (!is_pre() && n < 400) begin
      cyc(1);
      n++;
    end
    chk(n == 31, "R7 counter cleared by manual reset", n, 31);

    // R3 self-refresh entry
    wr_timer(1'b1, 1'b1, 200, 0);
    wr_ctl(1'b1, 1'b1);
    wait_pre(n);
    chk(is_pre() && sd_a10 && sd_cke, "R3 entry precharge", sd_a10, 1);
    cyc(1);
    chk(is_ref() && !sd_cke, "R3 refresh with cke low", sd_cke, 0);
    bad = 0;
    for (int k = 0; k < 260; k++) begin
      cyc(1);
      if (!(is_nop() && !sd_cke && rf_busy)) bad++;
    end
    chk(bad == 0, "R3 held quiet", bad, 0);

    // R7 manual reset during self-refresh
    mrst_n = 1'b0;
    cyc(1);
    mrst_n = 1'b1;
    cyc(5);
    chk(!sd_cke && rf_busy, "R7 self-refresh kept", sd_cke, 0);

    // R8 standby
    standby = 1'b1; hiz_keep = 1'b1;
    cyc(3);
    chk(sd_oe && !sd_cke, "R8 standby driven", sd_oe, 1);
    hiz_keep = 1'b0;
    cyc(3);
    chk(!sd_oe, "R8 standby released", sd_oe, 0);
    chk(!sd_cke, "R8 cke low in standby", sd_cke, 0);
    standby = 1'b0;
    cyc(3);
    chk(sd_oe && !sd_cke, "R8 after standby", sd_cke, 0);

    // R4 / R6 exit with preload
    wr_timer(1'b1, 1'b1, 20, 19);
    wr_ctl(1'b1, 1'b0);
    wait_cke(1'b1, n);
    chk(sd_cke && rf_busy && is_nop(), "R4 cke rise with post-wait", rf_busy, 1);
    n = 0;
    while (rf_busy && n < 50) begin
      n++;
      cyc(1);
    end
    chk(n == TPW, "R4 post-wait length", n, TPW);
    n = 0;
    while (!is_pre() && n < 400) begin
      cyc(1);
      n++;
    end
    chk(n == 2, "R6 immediate refresh after exit", n, 2);

    // R5 exit with refresh disabled
    wr_timer(1'b1, 1'b1, 12, 0);
    wr_ctl(1'b1, 1'b1);
    wait_cke(1'b0, n);
    cyc(10);
    wr_ctl(1'b0, 1'b0);
    wait_cke(1'b1, n);
    chk(sd_cke == 1'b1, "R5 exit done", sd_cke, 1);
    bad = 0;
    for (int k = 0; k < 80; k++) begin
      cyc(1);
      if (!is_nop()) bad++;
    end
    chk(bad == 0, "R5 no refresh when disabled", bad, 0);

    // R9 power-on reset during self-refresh
    wr_ctl(1'b1, 1'b1);
    wait_cke(1'b0, n);
    cyc(8);
    chk(!sd_cke, "R9 in self-refresh before reset", sd_cke, 0);
    por_n = 1'b0;
    #1;
    chk(sd_cke && !rf_busy && is_nop(), "R9 reset clears self-refresh", sd_cke, 1);
    cyc(2);
    por_n = 1'b1;
    cyc(4);
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      cyc(1);
      if (!is_nop() || !sd_cke) bad++;
    end
    chk(bad == 0, "R9 no activity after reset", bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule